// File: doc/BRIEF.md
# Framed Byte-Stream Packet Deserializer

This block sits on the receive side of a point-to-point link. Each rising edge of the link clock delivers one byte, and a frame signal marks when a transfer is under way. The block finds the start of each transaction, pulls the header and payload fields out of a fixed byte layout and assembles them into one 104-bit system packet. It marks each finished packet with a one-cycle valid strobe.

Byte 0 carries only the read flag. Bytes 1 to 5 form the header: routing control, destination address, size code, and the write and access flags. Bytes 6 to 13 carry the payload. If the frame stays high after the last byte, the link is in burst mode. The next byte is then the first payload byte of a new transaction, which reuses the header with the destination address moved on by 8. If the frame falls right after the low data word, the block emits a 32-bit transaction. If it falls anywhere else, the block discards the partial transaction.

The block keeps two slot counters, one for read traffic and one for write traffic. Each counter is charged by the packets of its class and released by a done pulse from the consumer. A wait output goes high when only one more transaction of that class can be accepted.

Top module: `link_pkt_deser`

## Requirements
- R1: A packet starts when frame_i is sampled high at a rising clock edge after being sampled low at the edge before (or after reset). The byte captured at that edge is byte 0, and bit 7 of byte 0 is the read flag (1 = read request).
- R2: Header bytes map as follows. Byte 1 is {ctrlmode[3:0], dstaddr[31:28]}. Bytes 2, 3 and 4 are dstaddr[27:20], [19:12] and [11:4]. Byte 5 is {dstaddr[3:0], datamode[1:0], write, access}. The datamode code is passed through unchanged: 00 is 8 bits, 01 is 16 bits, 10 is 32 bits and 11 is 64 bits.
- R3: Bytes 6 to 9 form data[31:0], most significant byte first. Bytes 10 to 13 form the upper word, most significant byte first. This word is the upper data of a write or the return address of a read, and it goes into the srcaddr field.
- R4: pkt_o places access at bit 0, write at bit 1, datamode at [3:2], ctrlmode at [7:4], dstaddr at [39:8], data at [71:40] and srcaddr at [103:72].
- R5: pkt_valid_o is high for exactly one cycle: the cycle after the edge that captures byte 13. pkt_o holds the completed packet in that cycle.
- R6: If frame_i is still high at the edge after byte 13, that byte is byte 6 of a new transaction. This transaction keeps ctrlmode, datamode, write, access and the read flag, and its dstaddr is the previous dstaddr plus 8.
- R7: If frame_i is sampled low when the next byte due is not byte 10, the transaction in progress is dropped and no valid pulse is produced for it.
- R8: If frame_i is sampled low at the edge right after byte 9, a 32-bit transaction is emitted with srcaddr = 0. pkt_valid_o is high in the cycle after that edge.
- R9: Each emitted packet charges the read counter (read flag 1) or the write counter (read flag 0) at its emitting edge. A high rd_done_i or wr_done_i sampled at an edge releases one slot. rd_wait_o and wr_wait_o are high while the count of their class is at least CREDITS-1.
- R10: After reset pkt_valid_o, rd_wait_o and wr_wait_o are low (CREDITS = 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock, one byte per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame signal for the byte stream |
| byte_i | input | 8 | Link byte |
| rd_done_i | input | 1 | Consumer releases one read slot |
| wr_done_i | input | 1 | Consumer releases one write slot |
| pkt_o | output | 104 | Assembled system packet |
| pkt_valid_o | output | 1 | One-cycle strobe for pkt_o |
| rd_wait_o | output | 1 | Only one more read transaction can be accepted |
| wr_wait_o | output | 1 | Only one more write transaction can be accepted |

## Verification
The valid strobe and the packet appear one cycle after the edge that samples byte 13. They also appear one cycle after the edge that samples a low frame right after byte 9. A wait output changes in that same valid cycle when a packet charges its counter, and one cycle after a sampled done pulse when a slot is released. The bench drives bytes and done pulses on falling edges. A behavioural model takes the same sampled inputs at each rising edge and predicts valid, packet and both waits. On the next falling edge every output is compared with that prediction. Directed checks on packet counts and on particular fields cover the burst address step, the short transaction, the aborted frames and the wait thresholds.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam int BYTE_W    = 8;
  localparam int POS_W     = 4;
  localparam int ADDR_STEP = 8;
  localparam logic [POS_W-1:0] POS_LAST  = 4'd13;
  localparam logic [POS_W-1:0] POS_BURST = 4'd6;
  localparam logic [POS_W-1:0] POS_SHORT = 4'd10;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] data;
    logic [31:0] dst;
    logic [3:0]  ctrl;
    logic [1:0]  mode;
    logic        wr;
    logic        acc;
  } pkt_t;
endpackage

// File: rtl/lpd_frame_track.sv
module lpd_frame_track
  import lpd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  output logic             cap_en_o,
  output logic [POS_W-1:0] cap_pos_o,
  output logic             emit_full_o,
  output logic             emit_short_o
);
  logic             frame_q;
  logic             active_q;
  logic [POS_W-1:0] pos_q;
  logic             start;

  assign start = frame_i & ~frame_q;

  always_comb begin
    cap_en_o     = start | (active_q & frame_i);
    cap_pos_o    = start ? '0 : pos_q;
    emit_full_o  = active_q & frame_i & (pos_q == POS_LAST);
    emit_short_o = active_q & ~frame_i & (pos_q == POS_SHORT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q  <= 1'b0;
      active_q <= 1'b0;
      pos_q    <= '0;
    end else begin
      frame_q <= frame_i;
      if (start) begin
        active_q <= 1'b1;
        pos_q    <= POS_W'(1);
      end else if (active_q && frame_i) begin
        pos_q <= (pos_q == POS_LAST) ? POS_BURST : pos_q + POS_W'(1);
      end else if (active_q) begin
        active_q <= 1'b0;
      end
    end
  end

  AST_BURST_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_full_o |=> (!cap_en_o || cap_pos_o == POS_BURST)); // R6
  AST_LOW_FRAME_NO_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |-> !emit_full_o); // R7
  AST_START_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !frame_q) |-> (cap_en_o && cap_pos_o == '0)); // R1
endmodule

// File: rtl/lpd_field_asm.sv
module lpd_field_asm
  import lpd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              cap_en_i,
  input  logic [POS_W-1:0]  cap_pos_i,
  input  logic              emit_full_i,
  input  logic              emit_short_i,
  output pkt_t              pkt_o,
  output logic              valid_o,
  output logic              rd_flag_o
);
  logic        rd_q, wr_q, acc_q;
  logic [3:0]  ctrl_q;
  logic [1:0]  mode_q;
  logic [31:0] dst_q, data_q;
  logic [23:0] src_q;
  pkt_t        pkt_q;
  logic        valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0; wr_q <= 1'b0; acc_q <= 1'b0;
      ctrl_q <= '0; mode_q <= '0;
      dst_q <= '0; data_q <= '0; src_q <= '0;
    end else if (cap_en_i) begin
      case (cap_pos_i)
        4'd0:  rd_q <= byte_i[7];
        4'd1:  begin ctrl_q <= byte_i[7:4]; dst_q[31:28] <= byte_i[3:0]; end
        4'd2:  dst_q[27:20] <= byte_i;
        4'd3:  dst_q[19:12] <= byte_i;
        4'd4:  dst_q[11:4]  <= byte_i;
        4'd5:  begin
          dst_q[3:0] <= byte_i[7:4];
          mode_q     <= byte_i[3:2];
          wr_q       <= byte_i[1];
          acc_q      <= byte_i[0];
        end
        4'd6:  data_q[31:24] <= byte_i;
        4'd7:  data_q[23:16] <= byte_i;
        4'd8:  data_q[15:8]  <= byte_i;
        4'd9:  data_q[7:0]   <= byte_i;
        4'd10: src_q[23:16]  <= byte_i;
        4'd11: src_q[15:8]   <= byte_i;
        4'd12: src_q[7:0]    <= byte_i;
        4'd13: dst_q <= dst_q + 32'(ADDR_STEP); // next burst beat
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= emit_full_i | emit_short_i;
      if (emit_full_i || emit_short_i) begin
        pkt_q.src  <= emit_full_i ? {src_q, byte_i} : 32'h0;
        pkt_q.data <= data_q;
        pkt_q.dst  <= dst_q;
        pkt_q.ctrl <= ctrl_q;
        pkt_q.mode <= mode_q;
        pkt_q.wr   <= wr_q;
        pkt_q.acc  <= acc_q;
      end
    end
  end

  assign pkt_o     = pkt_q;
  assign valid_o   = valid_q;
  assign rd_flag_o = rd_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5
  AST_SHORT_SRC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_short_i |=> (valid_o && pkt_o.src == 32'h0)); // R8
  AST_HEADER_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && cap_pos_i > 4'd5) |=> $stable(ctrl_q) && $stable(mode_q)); // R6
endmodule

// File: rtl/lpd_credit.sv
module lpd_credit #(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic give_i,
  output logic wait_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_WAIT = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case ({take_i, give_i})
        2'b10: if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
        2'b01: if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
        default: ;
      endcase
    end
  end

  assign wait_o = (cnt_q >= CNT_WAIT);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R9
  AST_WAIT_ON_LAST_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !give_i && cnt_q == CNT_W'(DEPTH - 2)) |=> wait_o); // R9
endmodule

// File: rtl/link_pkt_deser.sv
module link_pkt_deser
  import lpd_pkg::*;
#(
  parameter int CREDITS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frame_i,
  input  logic [7:0]   byte_i,
  input  logic         rd_done_i,
  input  logic         wr_done_i,
  output logic [103:0] pkt_o,
  output logic         pkt_valid_o,
  output logic         rd_wait_o,
  output logic         wr_wait_o
);
  localparam int N_CLS = 2; // 0: read, 1: write

  logic             cap_en, emit_full, emit_short, rd_flag;
  logic [POS_W-1:0] cap_pos;
  pkt_t             pkt;
  logic [N_CLS-1:0] take, give, wt;

  lpd_frame_track u_trk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_i      (frame_i),
    .cap_en_o     (cap_en),
    .cap_pos_o    (cap_pos),
    .emit_full_o  (emit_full),
    .emit_short_o (emit_short)
  );

  lpd_field_asm u_asm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_i       (byte_i),
    .cap_en_i     (cap_en),
    .cap_pos_i    (cap_pos),
    .emit_full_i  (emit_full),
    .emit_short_i (emit_short),
    .pkt_o        (pkt),
    .valid_o      (pkt_valid_o),
    .rd_flag_o    (rd_flag)
  );

  assign take[0] = (emit_full | emit_short) & rd_flag;
  assign take[1] = (emit_full | emit_short) & ~rd_flag;
  assign give    = {wr_done_i, rd_done_i};

  for (genvar g = 0; g < N_CLS; g++) begin : g_cls
    lpd_credit #(.DEPTH(CREDITS)) u_cr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (take[g]),
      .give_i (give[g]),
      .wait_o (wt[g])
    );
  end

  assign rd_wait_o = wt[0];
  assign wr_wait_o = wt[1];
  assign pkt_o     = pkt;

  AST_ONE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take)); // R9
endmodule

// File: tb/sim_link_pkt_deser.sv
module sim_link_pkt_deser;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame = 1'b0;
  logic [7:0]   byte_d = 8'h0;
  logic         rd_done = 1'b0, wr_done = 1'b0;
  logic [103:0] pkt;
  logic         pkt_valid, rd_wait, wr_wait;

  int checks = 0, errors = 0, n_valid = 0;
  logic [103:0] last_pkt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_pkt_deser #(.CREDITS(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .byte_i(byte_d),
    .rd_done_i(rd_done), .wr_done_i(wr_done),
    .pkt_o(pkt), .pkt_valid_o(pkt_valid), .rd_wait_o(rd_wait), .wr_wait_o(wr_wait)
  );

  // behavioural reference
  logic [7:0]   mb [14];
  int           midx, rcnt, wcnt;
  bit           mact, mprev, exp_valid;
  logic [31:0]  maddr;
  logic [103:0] exp_pkt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      midx = 0; mact = 0; mprev = 0; exp_valid = 0; rcnt = 0; wcnt = 0;
      maddr = '0; exp_pkt = '0;
      for (int i = 0; i < 14; i++) mb[i] = 8'h0;
    end else begin
      exp_valid = 0;
      if (frame && !mprev) begin
        mb[0] = byte_d; midx = 1; mact = 1;
      end else if (mact && frame) begin
        mb[midx] = byte_d;
        if (midx == 5) maddr = {mb[1][3:0], mb[2], mb[3], mb[4], mb[5][7:4]};
        if (midx == 13) begin
          exp_pkt = {mb[10], mb[11], mb[12], mb[13], mb[6], mb[7], mb[8], mb[9],
                     maddr, mb[1][7:4], mb[5][3:0]};
          exp_valid = 1;
          maddr = maddr + 32'd8;
          midx = 6;
        end else midx++;
      end else if (mact) begin
        if (midx == 10) begin
          exp_pkt = {32'h0, mb[6], mb[7], mb[8], mb[9], maddr, mb[1][7:4], mb[5][3:0]};
          exp_valid = 1;
        end
        mact = 0;
      end
      mprev = frame;
      if (exp_valid) begin
        if (mb[0][7]) rcnt++; else wcnt++;
      end
      if (rd_done && rcnt > 0) rcnt--;
      if (wr_done && wcnt > 0) wcnt--;
    end
  end

  task automatic chk(input string tag, input logic [103:0] act, input logic [103:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R10 valid in reset", 104'(pkt_valid), 104'(0));
      chk("R10 waits in reset", 104'({rd_wait, wr_wait}), 104'(0));
    end else begin
      chk("R5 valid strobe", 104'(pkt_valid), 104'(exp_valid));
      if (exp_valid) chk("R4 packet layout", pkt, exp_pkt);
      chk("R9 rd_wait", 104'(rd_wait), 104'(rcnt >= 3));
      chk("R9 wr_wait", 104'(wr_wait), 104'(wcnt >= 3));
      if (pkt_valid) begin n_valid++; last_pkt = pkt; end
    end
  end

  task automatic drv(input logic f, input logic [7:0] b);
    @(negedge clk); frame = f; byte_d = b;
  endtask
  task automatic hdr(input bit rd, input logic [3:0] c, input logic [31:0] d,
                     input logic [1:0] m, input bit w, input bit a);
    drv(1, {rd, 7'h0}); drv(1, {c, d[31:28]}); drv(1, d[27:20]);
    drv(1, d[19:12]); drv(1, d[11:4]); drv(1, {d[3:0], m, w, a});
  endtask
  task automatic word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) drv(1, w[i*8 +: 8]);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(0, 8'h0);
  endtask
  task automatic give(input bit rd);
    @(negedge clk); frame = 0; rd_done = rd; wr_done = !rd;
    @(negedge clk); rd_done = 0; wr_done = 0;
  endtask
  task automatic count_chk(input string tag, input int base, input int exp);
    @(negedge clk); #1;
    chk(tag, 104'(n_valid - base), 104'(exp));
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;

    base = n_valid;  // full write
    hdr(0, 4'h3, 32'h1234_5678, 2'b11, 1, 1); word(32'hDEAD_BEEF); word(32'hCAFE_F00D); idle(3);
    count_chk("R1 one packet per frame", base, 1);
    chk("R2 R3 write packet", last_pkt,
        {32'hCAFE_F00D, 32'hDEAD_BEEF, 32'h1234_5678, 4'h3, 2'b11, 1'b1, 1'b1});
    give(0);

    base = n_valid;  // read request
    hdr(1, 4'h0, 32'h8100_0040, 2'b10, 0, 1); word(32'h0); word(32'hAABB_CCDD); idle(3);
    count_chk("R1 read packet count", base, 1);
    chk("R3 srcaddr field", 104'(last_pkt[103:72]), 104'(32'hAABB_CCDD));
    chk("R2 write bit clear", 104'(last_pkt[1]), 104'(0));

    base = n_valid;  // burst of three
    hdr(0, 4'h5, 32'h2000_0000, 2'b11, 1, 1);
    for (int i = 0; i < 3; i++) begin word(32'h100 + i); word(~(32'h100 + i)); end
    idle(3);
    count_chk("R6 burst count", base, 3);
    chk("R6 burst dst step", 104'(last_pkt[39:8]), 104'(32'h2000_0010));
    chk("R6 burst ctrl reuse", 104'(last_pkt[7:4]), 104'(4'h5));
    give(0); give(0); give(0);

    base = n_valid;  // short 32-bit
    hdr(0, 4'h1, 32'h3000_0004, 2'b10, 1, 1); word(32'h1122_3344); idle(3);
    count_chk("R8 short count", base, 1);
    chk("R8 short packet", last_pkt,
        {32'h0, 32'h1122_3344, 32'h3000_0004, 4'h1, 2'b10, 1'b1, 1'b1});
    give(0);

    base = n_valid;  // burst ending short
    hdr(0, 4'h2, 32'h4000_0000, 2'b10, 1, 1); word(32'h1); word(32'h2); word(32'h5566_7788); idle(3);
    count_chk("R8 burst tail count", base, 2);
    chk("R6 R8 tail dst", 104'(last_pkt[39:8]), 104'(32'h4000_0008));
    chk("R8 tail src", 104'(last_pkt[103:72]), 104'(0));
    give(0); give(0);

    base = n_valid;  // aborts
    drv(1, 8'h0); drv(1, 8'h11); drv(1, 8'h22); drv(1, 8'h33); idle(3);
    hdr(0, 4'h0, 32'h5000_0000, 2'b11, 1, 1); word(32'h9); drv(1, 8'h1); drv(1, 8'h2); idle(3);
    hdr(0, 4'h0, 32'h5000_0000, 2'b11, 1, 1); drv(1, 8'h7); drv(1, 8'h8); idle(3);
    count_chk("R7 aborted frames", base, 0);

    // read slots: one held from earlier, two more reach the wait level
    for (int i = 0; i < 2; i++) begin
      hdr(1, 4'h0, 32'h6000_0000, 2'b10, 0, 1); word(32'h0); word(32'h1); idle(2);
    end
    @(negedge clk); #1;
    chk("R9 rd_wait at last slot", 104'(rd_wait), 104'(1));
    chk("R9 wr_wait independent", 104'(wr_wait), 104'(0));
    give(1);
    @(negedge clk); #1;
    chk("R9 rd_wait released", 104'(rd_wait), 104'(0));
    give(1); give(1);
    idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule